// File: doc/BRIEF.md
# Descriptor chain fetcher

This block is the front end of a DMA engine that walks a linked chain of descriptors kept in memory. A start pulse loads the list pointer from `list_base`. For each descriptor the fetcher reads the words it needs over a simple request/acknowledge memory read port. It checks the descriptor and then streams the source buffer to a downstream consumer as 32-bit beats on a valid/ready interface. When the descriptor is done, it either follows the next pointer or stops, depending on the descriptor's last flag. Completion and error conditions leave as single-cycle event pulses, ready to be routed into an interrupt status block.

A descriptor occupies eight consecutive 32-bit words. Word 0 is the source address, word 1 the source length in bytes, word 4 the user flags, word 6 the control word and word 7 the next-descriptor address. Words 2, 3 and 5 belong to the write path and are never read. Control bits: bit0 last descriptor, bit1 pause before streaming, bit8 list-done event wanted, bit9 destination-done event, bit10 source-done event. User bits [8:0] travel with every beat. Bit1 (string start) and bit2 (string end) are special and are described in R4.

The controller has these states:
- IDLE waits for start. IDLE goes to FETCH, or to LERR when the base is misaligned.
- FETCH reads the descriptor words and goes to CHECK after word 7.
- CHECK goes to ZERR, LERR, HOLD or READ.
- HOLD waits for restart and then goes to READ.
- READ fetches one source word and goes to SEND.
- SEND offers the beat. It goes back to READ, or to WRAP after the final beat.
- WRAP raises the per-descriptor events. It goes to FETCH at the next pointer, or to IDLE after a last descriptor.
- LERR and ZERR each raise their event for one cycle and then go to IDLE.

Top module: `desc_chain_fetcher`

## Requirements
- R1: After reset the block is idle: `busy`, `paused`, `mem_req`, `out_valid` and all event outputs are 0. While idle, no memory request and no beat is issued.
- R2: A start pulse while idle, with a 4-byte-aligned `list_base`, reads the descriptor at that address. The read addresses are base+0, base+4, base+16, base+24, base+28, in that order. A start pulse while busy is ignored and does not reload the pointer.
- R3: A descriptor of length L bytes (L>0) produces ceil(L/4) beats. Beat k carries the memory word at source address + 4k. `out_nbytes` is 4 on every beat except the final one, which carries L mod 4, or 4 when L is a multiple of 4.
- R4: `out_first` is 1 only on a descriptor's first beat and `out_last` only on its final beat. `out_user` repeats user bits [8:0] on every beat, except that bit1 appears only on the first beat and bit2 only on the final beat.
- R5: After a descriptor whose control bit0 is 0, the next descriptor is read from its next pointer. After one whose bit0 is 1, the block goes idle and pulses `evt_list_done` once if control bit8 is set, and not at all otherwise.
- R6: Each streamed descriptor pulses `evt_src_done` once if control bit10 is set and `evt_dst_done` once if bit9 is set.
- R7: A descriptor with control bit1 set holds in a paused state after its fetch: `paused`=1, with no memory request and no beat. A restart pulse then streams that same descriptor. A restart at any other time is ignored.
- R8: A descriptor with length 0 pulses `evt_zero_len` once, streams nothing, and leaves the block idle.
- R9: A misaligned list base, a misaligned source address, or a misaligned next pointer on a non-last descriptor pulses `evt_list_err` once, streams nothing from that descriptor, and leaves the block idle. The next pointer of a last descriptor is never checked.
- R10: While `out_valid` is 1 and `out_ready` is 0, the beat stays offered with unchanged data and flags.
- R11: A memory request, once raised, stays raised with a stable, word-aligned address until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin walking the list at `list_base` |
| restart | input | 1 | Resume a paused descriptor |
| list_base | input | ADDR_W | Byte address of the first descriptor |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Byte address of the requested word |
| mem_ack | input | 1 | Read acknowledge; `mem_rdata` is valid in the same cycle |
| mem_rdata | input | 32 | Read data |
| out_valid | output | 1 | Beat offered |
| out_ready | input | 1 | Consumer accepts the beat |
| out_data | output | 32 | Beat data |
| out_first | output | 1 | First beat of a descriptor |
| out_last | output | 1 | Final beat of a descriptor |
| out_nbytes | output | 3 | Valid bytes in the beat (1 to 4) |
| out_user | output | 9 | Forwarded user flags |
| busy | output | 1 | Not idle |
| paused | output | 1 | Holding before a paused descriptor's data |
| evt_list_done | output | 1 | List-done event pulse |
| evt_src_done | output | 1 | Source-done event pulse |
| evt_dst_done | output | 1 | Destination-done event pulse |
| evt_zero_len | output | 1 | Zero-length event pulse |
| evt_list_err | output | 1 | Malformed-chain event pulse |

## Verification
The first sweep runs single-descriptor lists with lengths from 1 to 12 bytes under changing backpressure and read latency. This separates the whole-word case from each partial final word, and it exposes any beat-count or byte-count slip as well as any loss of data while the consumer stalls. Multi-descriptor chains mix control bits to show that following the next pointer, pausing with restart, and the per-descriptor events stay separate. Two further cases show that a list-done pulse appears only when requested, and that a stray start during a run does not reload the pointer. Zero lengths and misaligned base, source and next addresses, placed first or mid-chain, show that each fault stops the walk with its own event. A misaligned pointer in a last descriptor shows that such a pointer is not treated as a fault.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
    localparam int WORD_BYTES = 4;
    localparam int ALN_W      = $clog2(WORD_BYTES);
    localparam int DESC_WORDS = 8;
    localparam int IDX_W      = $clog2(DESC_WORDS);
    localparam int USER_W     = 9;
    localparam int NB_W       = ALN_W + 1;

    // word positions inside a descriptor
    localparam logic [IDX_W-1:0] IX_SRC  = 3'd0;
    localparam logic [IDX_W-1:0] IX_LEN  = 3'd1;
    localparam logic [IDX_W-1:0] IX_USER = 3'd4;
    localparam logic [IDX_W-1:0] IX_CTRL = 3'd6;
    localparam logic [IDX_W-1:0] IX_NEXT = 3'd7;

    // control word bit positions
    localparam int CB_LAST  = 0;
    localparam int CB_PAUSE = 1;
    localparam int CB_LDONE = 8;
    localparam int CB_DDONE = 9;
    localparam int CB_SDONE = 10;

    // user flag positions that are beat-qualified
    localparam int UB_SSTART = 1;
    localparam int UB_SEND   = 2;

    typedef struct packed {
        logic last;
        logic pause;
        logic ldone;
        logic ddone;
        logic sdone;
    } ctrl_t;

    typedef enum logic [3:0] {
        S_IDLE, S_FETCH, S_CHECK, S_HOLD, S_READ,
        S_SEND, S_WRAP, S_LERR, S_ZERR
    } fsm_t;

    // only the descriptor words that matter are visited
    function automatic logic [IDX_W-1:0] next_idx(input logic [IDX_W-1:0] i);
        case (i)
            IX_SRC:  return IX_LEN;
            IX_LEN:  return IX_USER;
            IX_USER: return IX_CTRL;
            default: return IX_NEXT;
        endcase
    endfunction
endpackage

// File: rtl/dcf_desc_regs.sv
module dcf_desc_regs
    import dcf_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [IDX_W-1:0]  cap_idx,
    input  logic [31:0]       cap_word,
    output logic [ADDR_W-1:0] src_addr,
    output logic [LEN_W-1:0]  src_len,
    output logic [USER_W-1:0] user,
    output ctrl_t             ctrl,
    output logic [ADDR_W-1:0] next_ptr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_addr <= '0;
            src_len  <= '0;
            user     <= '0;
            ctrl     <= '0;
            next_ptr <= '0;
        end else if (cap_en) begin
            case (cap_idx)
                IX_SRC:  src_addr <= cap_word[ADDR_W-1:0];
                IX_LEN:  src_len  <= cap_word[LEN_W-1:0];
                IX_USER: user     <= cap_word[USER_W-1:0];
                IX_CTRL: ctrl     <= '{last:  cap_word[CB_LAST],
                                       pause: cap_word[CB_PAUSE],
                                       ldone: cap_word[CB_LDONE],
                                       ddone: cap_word[CB_DDONE],
                                       sdone: cap_word[CB_SDONE]};
                IX_NEXT: next_ptr <= cap_word[ADDR_W-1:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/dcf_beat_ctr.sv
module dcf_beat_ctr
    import dcf_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [LEN_W-1:0]  load_len,
    input  logic              step,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              first,
    output logic              final_beat,
    output logic [NB_W-1:0]   nbytes
);
    localparam logic [ADDR_W-1:0] A_STEP = ADDR_W'(WORD_BYTES);
    localparam logic [LEN_W-1:0]  L_STEP = LEN_W'(WORD_BYTES);

    logic [LEN_W-1:0] rem_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr <= '0;
            rem_q    <= '0;
            first    <= 1'b0;
        end else if (load) begin
            cur_addr <= load_addr;
            rem_q    <= load_len;
            first    <= 1'b1;
        end else if (step) begin
            cur_addr <= cur_addr + A_STEP;
            rem_q    <= rem_q - L_STEP;
            first    <= 1'b0;
        end
    end

    assign final_beat = (rem_q <= L_STEP);
    always_comb begin
        if (final_beat && rem_q[ALN_W-1:0] != '0)
            nbytes = {1'b0, rem_q[ALN_W-1:0]};
        else
            nbytes = NB_W'(WORD_BYTES);
    end
endmodule

// File: rtl/desc_chain_fetcher.sv
module desc_chain_fetcher
    import dcf_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              restart,
    input  logic [ADDR_W-1:0] list_base,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [31:0]       out_data,
    output logic              out_first,
    output logic              out_last,
    output logic [2:0]        out_nbytes,
    output logic [8:0]        out_user,
    output logic              busy,
    output logic              paused,
    output logic              evt_list_done,
    output logic              evt_src_done,
    output logic              evt_dst_done,
    output logic              evt_zero_len,
    output logic              evt_list_err
);
    fsm_t              state_q, state_d;
    logic [ADDR_W-1:0] ptr_q;
    logic [IDX_W-1:0]  idx_q;
    logic [31:0]       data_q;

    logic [ADDR_W-1:0] d_src, d_next, b_addr;
    logic [LEN_W-1:0]  d_len;
    logic [USER_W-1:0] d_user;
    ctrl_t             d_ctrl;
    logic              b_first, b_final;
    logic [NB_W-1:0]   b_nbytes;
    logic              base_bad, desc_bad, len_zero;

    assign base_bad = list_base[ALN_W-1:0] != '0;
    assign len_zero = d_len == '0;
    assign desc_bad = (d_src[ALN_W-1:0] != '0) ||
                      (!d_ctrl.last && d_next[ALN_W-1:0] != '0);

    dcf_desc_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_desc (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (state_q == S_FETCH && mem_ack),
        .cap_idx  (idx_q),
        .cap_word (mem_rdata),
        .src_addr (d_src),
        .src_len  (d_len),
        .user     (d_user),
        .ctrl     (d_ctrl),
        .next_ptr (d_next)
    );

    dcf_beat_ctr #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_beat (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (state_q == S_CHECK),
        .load_addr  (d_src),
        .load_len   (d_len),
        .step       (state_q == S_SEND && out_ready && !b_final),
        .cur_addr   (b_addr),
        .first      (b_first),
        .final_beat (b_final),
        .nbytes     (b_nbytes)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start) state_d = base_bad ? S_LERR : S_FETCH;
            S_FETCH: if (mem_ack && idx_q == IX_NEXT) state_d = S_CHECK;
            S_CHECK: begin
                if (len_zero)          state_d = S_ZERR;
                else if (desc_bad)     state_d = S_LERR;
                else if (d_ctrl.pause) state_d = S_HOLD;
                else                   state_d = S_READ;
            end
            S_HOLD:  if (restart) state_d = S_READ;
            S_READ:  if (mem_ack) state_d = S_SEND;
            S_SEND:  if (out_ready) state_d = b_final ? S_WRAP : S_READ;
            S_WRAP:  state_d = d_ctrl.last ? S_IDLE : S_FETCH;
            S_LERR:  state_d = S_IDLE;
            S_ZERR:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // list pointer, word index and beat holding register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            idx_q  <= IX_SRC;
            data_q <= '0;
        end else begin
            if (state_q == S_IDLE && start) begin
                ptr_q <= list_base;
                idx_q <= IX_SRC;
            end
            if (state_q == S_FETCH && mem_ack) idx_q <= next_idx(idx_q);
            if (state_q == S_WRAP && !d_ctrl.last) begin
                ptr_q <= d_next;
                idx_q <= IX_SRC;
            end
            if (state_q == S_READ && mem_ack) data_q <= mem_rdata;
        end
    end

    // outputs
    always_comb begin
        mem_req       = 1'b0;
        mem_addr      = ptr_q + ADDR_W'({idx_q, {ALN_W{1'b0}}});
        out_valid     = 1'b0;
        paused        = 1'b0;
        evt_list_done = 1'b0;
        evt_src_done  = 1'b0;
        evt_dst_done  = 1'b0;
        evt_zero_len  = 1'b0;
        evt_list_err  = 1'b0;
        unique case (state_q)
            S_FETCH: mem_req = 1'b1;
            S_READ: begin
                mem_req  = 1'b1;
                mem_addr = b_addr;
            end
            S_SEND:  out_valid = 1'b1;
            S_HOLD:  paused = 1'b1;
            S_WRAP: begin
                evt_list_done = d_ctrl.last && d_ctrl.ldone;
                evt_src_done  = d_ctrl.sdone;
                evt_dst_done  = d_ctrl.ddone;
            end
            S_LERR:  evt_list_err = 1'b1;
            S_ZERR:  evt_zero_len = 1'b1;
            default: ;
        endcase
    end

    assign busy       = state_q != S_IDLE;
    assign out_data   = data_q;
    assign out_first  = b_first;
    assign out_last   = b_final;
    assign out_nbytes = b_nbytes;

    // per-bit user forwarding: string start/end bits qualified by beat position
    for (genvar i = 0; i < USER_W; i++) begin : g_user
        if (i == UB_SSTART) begin : g_ss
            assign out_user[i] = d_user[i] & b_first;
        end else if (i == UB_SEND) begin : g_se
            assign out_user[i] = d_user[i] & b_final;
        end else begin : g_pl
            assign out_user[i] = d_user[i];
        end
    end
endmodule

// File: rtl/dcf_checker.sv
module dcf_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ack,
    input logic              out_valid,
    input logic              out_ready,
    input logic [31:0]       out_data,
    input logic              out_first,
    input logic              out_last,
    input logic [2:0]        out_nbytes,
    input logic [8:0]        out_user,
    input logic              busy,
    input logic              paused,
    input logic              evt_zero_len,
    input logic              evt_list_err
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !out_valid && !paused)); // R1

    AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
        $stable(out_first) && $stable(out_last) && $stable(out_nbytes) &&
        $stable(out_user))); // R10

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R11

    AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00)); // R11

    AST_PAUSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        paused |-> (!mem_req && !out_valid)); // R7

    AST_FAULT_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({evt_list_err, evt_zero_len, mem_req, out_valid})); // R9

    AST_FULL_MIDBEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |-> (out_nbytes == 3'd4)); // R3
endmodule

bind desc_chain_fetcher dcf_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mem_req      (mem_req),
    .mem_addr     (mem_addr),
    .mem_ack      (mem_ack),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_data     (out_data),
    .out_first    (out_first),
    .out_last     (out_last),
    .out_nbytes   (out_nbytes),
    .out_user     (out_user),
    .busy         (busy),
    .paused       (paused),
    .evt_zero_len (evt_zero_len),
    .evt_list_err (evt_list_err)
);

// File: tb/desc_chain_fetcher_tb.sv
module desc_chain_fetcher_tb;
    localparam logic [31:0] C_LAST = 32'h001, C_PAUSE = 32'h002,
                            C_LD = 32'h100, C_DD = 32'h200, C_SD = 32'h400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, restart = 1'b0;
    logic [31:0] list_base = '0;
    logic        mem_req, mem_ack;
    logic [31:0] mem_addr, mem_rdata;
    logic        out_valid, out_first, out_last;
    logic        out_ready = 1'b0;
    logic [31:0] out_data;
    logic [2:0]  out_nbytes;
    logic [8:0]  out_user;
    logic        busy, paused;
    logic        evt_list_done, evt_src_done, evt_dst_done, evt_zero_len, evt_list_err;

    logic [31:0] mem [0:255];
    logic        ack_en = 1'b0;
    logic        rdy_mode = 1'b0, ack_mode = 1'b0;
    logic [15:0] lf = 16'hACE1;

    int nchk = 0, nerr = 0;
    int nbeats = 0, nreads = 0;
    int n_ld = 0, n_sd = 0, n_dd = 0, n_zero = 0, n_err = 0;
    logic [31:0] g_data [0:63];
    logic [2:0]  g_nb   [0:63];
    logic        g_first[0:63];
    logic        g_last [0:63];
    logic [8:0]  g_user [0:63];
    logic [31:0] rd_addr[0:127];

    always #10 clk = ~clk;

    assign mem_ack   = mem_req & ack_en;
    assign mem_rdata = mem[mem_addr[9:2]];

    desc_chain_fetcher u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .restart(restart),
        .list_base(list_base), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .out_first(out_first),
        .out_last(out_last), .out_nbytes(out_nbytes), .out_user(out_user),
        .busy(busy), .paused(paused), .evt_list_done(evt_list_done),
        .evt_src_done(evt_src_done), .evt_dst_done(evt_dst_done),
        .evt_zero_len(evt_zero_len), .evt_list_err(evt_list_err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // drive handshake inputs at the falling edge, then record what the next rising edge takes
    always @(negedge clk) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        out_ready = rdy_mode ? (lf[0] | lf[3]) : 1'b1;
        ack_en    = ack_mode ? (lf[1] | lf[5]) : 1'b1;
        #1;
        if (rst_n) begin
            if (out_valid && out_ready && nbeats < 64) begin
                g_data[nbeats] = out_data;  g_nb[nbeats] = out_nbytes;
                g_first[nbeats] = out_first; g_last[nbeats] = out_last;
                g_user[nbeats] = out_user;  nbeats++;
            end
            if (mem_req && mem_ack && nreads < 128) begin
                rd_addr[nreads] = mem_addr; nreads++;
            end
            n_ld += int'(evt_list_done); n_sd += int'(evt_src_done);
            n_dd += int'(evt_dst_done);  n_zero += int'(evt_zero_len);
            n_err += int'(evt_list_err);
        end
    end

    task automatic put_desc(input int w, input logic [31:0] src, input logic [31:0] len,
                            input logic [8:0] user, input logic [31:0] ctrl,
                            input logic [31:0] nxt);
        mem[w] = src;  mem[w+1] = len; mem[w+2] = 32'hD0D0_0000 + 32'(w);
        mem[w+3] = 32'h40; mem[w+4] = {23'h7F_FFFF, user}; mem[w+5] = 32'hFFFF_FFFF;
        mem[w+6] = ctrl; mem[w+7] = nxt;
    endtask

    task automatic run_chain(input logic [31:0] base, input bit poke);
        int cyc = 0, pc = 0, hold_b = 0, hold_r = 0, n_pause = 0;
        bit prev_p = 0;
        int e_ld = 0, e_sd = 0, e_dd = 0, e_zero = 0, e_err = 0, e_pause = 0, eb = 0;
        logic [31:0] ptr;
        nbeats = 0; nreads = 0; n_ld = 0; n_sd = 0; n_dd = 0; n_zero = 0; n_err = 0;
        @(negedge clk); list_base = base; start = 1'b1;
        @(negedge clk); start = 1'b0; list_base = 32'h3;
        forever begin
            @(negedge clk); #2;
            start = 1'b0; restart = 1'b0;
            if (!busy) break;
            cyc++;
            if (cyc > 4000) begin chk(0, "R5", "walk watchdog", 32'(cyc), 32'd4000); break; end
            if (poke && cyc == 3) start = 1'b1;
            if (paused) begin
                if (!prev_p) begin n_pause++; hold_b = nbeats; hold_r = nreads; pc = 0; end
                pc++;
                if (pc == 6) begin
                    chk(nbeats == hold_b && nreads == hold_r, "R7", "activity while paused",
                        32'(nbeats + nreads), 32'(hold_b + hold_r));
                    restart = 1'b1;
                end
            end
            prev_p = paused;
        end
        start = 1'b0; restart = 1'b0;
        // expected behaviour from the descriptor contents
        ptr = base;
        if (ptr[1:0] != 2'b00) e_err = 1;
        else begin
            for (int d = 0; d < 8; d++) begin
                int w = int'(ptr[9:2]);
                logic [31:0] src = mem[w], len = mem[w+1], ctl = mem[w+6], nxt = mem[w+7];
                logic [8:0] u = mem[w+4][8:0];
                int nb;
                if (d == 0) begin
                    int off[5] = '{0, 4, 16, 24, 28};
                    bit ok = nreads >= 5;
                    for (int j = 0; j < 5; j++) if (ok && rd_addr[j] != ptr + 32'(off[j])) ok = 0;
                    chk(ok, "R2", "descriptor read order", rd_addr[4], ptr + 32'd28);
                end
                if (len == 0) begin e_zero++; break; end
                if (src[1:0] != 0 || (!ctl[0] && nxt[1:0] != 0)) begin e_err++; break; end
                if (ctl[1]) e_pause++;
                nb = int'((len + 3) / 4);
                for (int k = 0; k < nb; k++) begin
                    logic [2:0] enb = (k == nb - 1 && len[1:0] != 0) ? {1'b0, len[1:0]} : 3'd4;
                    logic [8:0] eu = u & ~9'h006;
                    if (k == 0) eu[1] = u[1];
                    if (k == nb - 1) eu[2] = u[2];
                    if (eb < nbeats) begin
                        chk(g_data[eb] == mem[(int'(src[9:2]) + k) & 255] && g_nb[eb] == enb,
                            "R3", "beat data/bytes", g_data[eb], mem[(int'(src[9:2]) + k) & 255]);
                        chk(g_first[eb] == (k == 0) && g_last[eb] == (k == nb - 1) && g_user[eb] == eu,
                            "R4", "beat flags/user", {g_first[eb], g_last[eb], 21'd0, g_user[eb]},
                            {k == 0, k == nb - 1, 21'd0, eu});
                    end
                    eb++;
                end
                e_sd += int'(ctl[10]); e_dd += int'(ctl[9]);
                if (ctl[0]) begin e_ld += int'(ctl[8]); break; end
                ptr = nxt;
            end
        end
        chk(nbeats == eb, "R3", "beat count", 32'(nbeats), 32'(eb));
        chk(n_ld == e_ld, "R5", "list-done pulses", 32'(n_ld), 32'(e_ld));
        chk(n_sd == e_sd && n_dd == e_dd, "R6", "src/dst-done pulses",
            32'(n_sd * 256 + n_dd), 32'(e_sd * 256 + e_dd));
        chk(n_pause == e_pause, "R7", "pause entries", 32'(n_pause), 32'(e_pause));
        chk(n_zero == e_zero, "R8", "zero-length pulses", 32'(n_zero), 32'(e_zero));
        chk(n_err == e_err, "R9", "list-error pulses", 32'(n_err), 32'(e_err));
    endtask

    initial begin
        #(20 * 150000);
        chk(0, "R1", "global watchdog", 32'd0, 32'd1);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 128; i++) mem[i] = '0;
        for (int i = 128; i < 256; i++) mem[i] = 32'(i) * 32'h9E37_79B1;
        repeat (3) @(negedge clk);
        #2;
        chk(!busy && !paused && !mem_req && !out_valid, "R1", "reset outputs",
            {28'd0, busy, paused, mem_req, out_valid}, 32'd0);
        chk({evt_list_done, evt_src_done, evt_dst_done, evt_zero_len, evt_list_err} == 0,
            "R1", "reset events", 32'({evt_list_done, evt_src_done, evt_dst_done,
            evt_zero_len, evt_list_err}), 32'd0);
        rst_n = 1'b1;
        // restart while idle has no effect
        @(negedge clk); restart = 1'b1;
        @(negedge clk); restart = 1'b0;
        @(negedge clk); #2;
        chk(!busy && nreads == 0 && nbeats == 0, "R7", "idle restart ignored",
            32'(busy), 32'd0);
        // length sweep, single last descriptor with list-done
        for (int len = 1; len <= 12; len++) begin
            put_desc(0, 32'(512 + 4 * len), 32'(len), 9'(len * 37), C_LAST | C_LD, 32'h0);
            rdy_mode = len[0]; ack_mode = len[1];
            run_chain(32'h0, 1'b0);
        end
        // three-descriptor chain with a pause and a stray start (R5 R6 R7 R2)
        rdy_mode = 1'b1; ack_mode = 1'b1;
        put_desc(16, 32'h240, 32'd9, 9'h007, C_SD, 32'h80);
        put_desc(32, 32'h260, 32'd4, 9'h180, C_DD | C_SD | C_PAUSE, 32'hC0);
        put_desc(48, 32'h280, 32'd6, 9'h00A, C_LAST | C_LD | C_DD, 32'h0);
        run_chain(32'h40, 1'b1);
        // last descriptor without list-done request, misaligned pointer not checked (R5 R9)
        rdy_mode = 1'b0; ack_mode = 1'b0;
        put_desc(0, 32'h200, 32'd5, 9'h1F6, C_LAST, 32'h43);
        run_chain(32'h0, 1'b0);
        // zero length first and mid-chain (R8)
        put_desc(0, 32'h200, 32'd0, 9'h0, C_LAST | C_LD, 32'h0);
        run_chain(32'h0, 1'b0);
        put_desc(0, 32'h204, 32'd3, 9'h006, C_SD, 32'h80);
        put_desc(32, 32'h200, 32'd0, 9'h0, C_LAST | C_LD, 32'h0);
        run_chain(32'h0, 1'b0);
        // malformed chains (R9)
        run_chain(32'h42, 1'b0);
        put_desc(0, 32'h200, 32'd8, 9'h0, C_SD, 32'h42);
        run_chain(32'h0, 1'b0);
        put_desc(0, 32'h201, 32'd8, 9'h0, C_LAST | C_LD, 32'h0);
        run_chain(32'h0, 1'b0);
        put_desc(0, 32'h208, 32'd7, 9'h0, C_DD, 32'h80);
        put_desc(32, 32'h20C, 32'd2, 9'h0, C_LAST, 32'h0);
        mem[32] = 32'h20E;
        run_chain(32'h0, 1'b0);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule